// File: doc/BRIEF.md
# Tagged-Word Transmit Loader with Receive Return Queue

This block is the data front end that sits between a register bus and the shift engine of a serial flash controller. Software writes 32-bit words to one of four transmit addresses. The address it chooses tells the block how many of the word's bytes are meaningful. Each accepted write becomes one entry in a 63-word transmit queue, and the entry carries a byte-count tag next to the data. The shift engine pops entries from the head of the queue and uses the tag to send only the meaningful bytes. Those bytes are always the least significant ones, so a short final word never puts filler bytes on the wire.

In the other direction, the shift engine pushes each received word into a 63-word receive queue together with its own byte count. The block stores the word right-aligned and forces every byte that was not received to zero. Software reads that queue at one address, and each read removes one word. The block exports the status the interrupt logic needs:
- transmit not full;
- transmit below a programmable threshold;
- receive not empty;
- a sticky flag that records a transmit write which was lost because the queue was full.

Top module: `sfc_txfront`

## Requirements
- R1: A bus write at address 0x1C queues the written word with byte tag 4, and the data comes out unchanged at the head of the transmit queue.
- R2: Bus writes at addresses 0x80, 0x84 and 0x88 queue the written word with byte tags 1, 2 and 3. The data word is kept as written, and the tag at the head is always in the range 1 to 4.
- R3: A bus write at any other address queues nothing. A bus read at any address other than 0x20 returns zero on the read data port and removes nothing.
- R4: The transmit queue holds up to 63 entries in arrival order. Its not-full flag is low exactly when 63 entries are held, and it stays low until an entry is popped.
- R5: A transmit write made while the queue is full is dropped and sets the overflow flag. That flag stays set until reset, and it is set only by such a write.
- R6: A shift-engine pop removes the head entry. A pop when the queue is empty has no effect. A write and a pop in the same cycle both take effect, except that the write is dropped when the queue was full before that cycle.
- R7: The below-threshold flag is high exactly when the transmit occupancy is less than the threshold input.
- R8: A receive push stores the word right-aligned. With a byte count of 1, 2 or 3, only that many low bytes are kept and the rest read as zero. Any other count keeps the full word. A push while 63 words are held is dropped.
- R9: A bus read at address 0x20 pops the oldest received word, which appears on the read data port after the next clock edge. If the receive queue is empty, the read returns zero and leaves the queue unchanged.
- R10: The receive not-empty flag is high exactly when at least one word is held.
- R11: After reset, both queues are empty, the overflow flag is clear and the read data port is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Registered bus read data |
| cfg_tx_thr | input | CNT_W | Transmit threshold level |
| eng_tx_pop | input | 1 | Shift engine takes the head transmit entry |
| eng_tx_word | output | DATA_W | Head transmit data word |
| eng_tx_bytes | output | TAG_W | Head transmit byte count |
| tx_has_data | output | 1 | Transmit queue holds an entry |
| tx_not_full | output | 1 | Transmit queue can accept a write |
| tx_below_thr | output | 1 | Transmit occupancy below threshold |
| tx_overflow | output | 1 | Sticky flag for a dropped transmit write |
| eng_rx_push | input | 1 | Shift engine delivers a received word |
| eng_rx_word | input | DATA_W | Received word, least significant bytes valid |
| eng_rx_bytes | input | TAG_W | Number of valid received bytes |
| rx_not_empty | output | 1 | Receive queue holds a word |
| rx_not_full | output | 1 | Receive queue can accept a push |

## Verification
On every cycle, the assertions check the following:
- the overflow flag is sticky and is only ever set by a transmit write made while the queue is full;
- a full queue stays full when no pop occurs;
- the head tag stays in range;
- a read at the wrong address, or of an empty receive queue, returns zero;
- a receive push into a non-full queue makes the not-empty flag rise.

Only the bench's reference queues can show that data and tags come out in arrival order. The same is true for the right-aligned masking of short received words, and for an empty read leaving the read pointer unchanged so that a later word is still returned intact.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int OFS_TX_FULL  = 'h1C;
  localparam int OFS_TX_ONE   = 'h80;
  localparam int OFS_TX_TWO   = 'h84;
  localparam int OFS_TX_THREE = 'h88;
  localparam int OFS_RX_POP   = 'h20;
endpackage

// File: rtl/sfc_wfifo.sv
module sfc_wfifo #(
  parameter int W     = 35,
  parameter int DEPTH = 63,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfc_txdec.sv
module sfc_txdec #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4,
  localparam int TAG_W = $clog2(NB + 1)
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              push,
  output logic [TAG_W-1:0]  tag
);
  import sfc_pkg::*;

  always_comb begin
    push = wr;
    tag  = TAG_W'(NB);
    if (addr == ADDR_W'(OFS_TX_FULL))       tag = TAG_W'(NB);
    else if (addr == ADDR_W'(OFS_TX_ONE))   tag = TAG_W'(1);
    else if (addr == ADDR_W'(OFS_TX_TWO))   tag = TAG_W'(2);
    else if (addr == ADDR_W'(OFS_TX_THREE)) tag = TAG_W'(3);
    else                                    push = 1'b0;
  end
endmodule

// File: rtl/sfc_rxalign.sv
module sfc_rxalign #(
  parameter int NB = 4,
  localparam int TAG_W = $clog2(NB + 1),
  localparam int DW    = NB * 8
) (
  input  logic [DW-1:0]    word_i,
  input  logic [TAG_W-1:0] nbytes,
  output logic [DW-1:0]    word_o
);
  logic whole;
  assign whole = (nbytes == '0) || (nbytes >= TAG_W'(NB));

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic keep;
    assign keep = whole || (TAG_W'(b) < nbytes);
    assign word_o[8*b +: 8] = keep ? word_i[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/sfc_txfront.sv
module sfc_txfront #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 63,
  localparam int NB    = DATA_W / 8,
  localparam int TAG_W = $clog2(NB + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cfg_tx_thr,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_word,
  output logic [TAG_W-1:0]  eng_tx_bytes,
  output logic              tx_has_data,
  output logic              tx_not_full,
  output logic              tx_below_thr,
  output logic              tx_overflow,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_word,
  input  logic [TAG_W-1:0]  eng_rx_bytes,
  output logic              rx_not_empty,
  output logic              rx_not_full
);
  import sfc_pkg::*;

  logic             tx_push;
  logic [TAG_W-1:0] tx_tag;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [DATA_W-1:0] rx_aligned, rx_head;
  logic             rx_sel;

  sfc_txdec #(.ADDR_W(ADDR_W), .NB(NB)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .push(tx_push), .tag(tx_tag)
  );

  sfc_wfifo #(.W(TAG_W + DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .din({tx_tag, bus_wdata}),
    .pop(eng_tx_pop), .dout({eng_tx_bytes, eng_tx_word}),
    .count(tx_cnt)
  );

  sfc_rxalign #(.NB(NB)) u_align (
    .word_i(eng_rx_word), .nbytes(eng_rx_bytes), .word_o(rx_aligned)
  );

  assign rx_sel = bus_rd && (bus_addr == ADDR_W'(OFS_RX_POP));

  sfc_wfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(eng_rx_push), .din(rx_aligned),
    .pop(rx_sel), .dout(rx_head),
    .count(rx_cnt)
  );

  assign tx_has_data  = (tx_cnt != '0);
  assign tx_not_full  = (tx_cnt != CNT_W'(DEPTH));
  assign tx_below_thr = (tx_cnt < cfg_tx_thr);
  assign rx_not_empty = (rx_cnt != '0);
  assign rx_not_full  = (rx_cnt != CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      tx_overflow <= 1'b0;
    end else begin
      if (tx_push && !tx_not_full) tx_overflow <= 1'b1;
      if (bus_rd) bus_rdata <= (rx_sel && rx_not_empty) ? rx_head : '0;
    end
  end
endmodule

// File: rtl/sfc_txfront_chk.sv
module sfc_txfront_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 63,
  localparam int NB    = DATA_W / 8,
  localparam int TAG_W = $clog2(NB + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_tx_pop,
  input logic [TAG_W-1:0]  eng_tx_bytes,
  input logic              tx_has_data,
  input logic              tx_not_full,
  input logic              tx_overflow,
  input logic              eng_rx_push,
  input logic              rx_not_empty,
  input logic              rx_not_full
);
  import sfc_pkg::*;

  logic is_tx, is_rx;
  assign is_tx = (bus_addr == ADDR_W'(OFS_TX_FULL)) || (bus_addr == ADDR_W'(OFS_TX_ONE)) ||
                 (bus_addr == ADDR_W'(OFS_TX_TWO))  || (bus_addr == ADDR_W'(OFS_TX_THREE));
  assign is_rx = (bus_addr == ADDR_W'(OFS_RX_POP));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |=> tx_overflow);

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_overflow) |-> $past(bus_wr && is_tx && !tx_not_full));

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tx_not_full && !eng_tx_pop) |=> !tx_not_full);

  assert_tag_range_R2: assert property (@(posedge clk) disable iff (rst)
    tx_has_data |-> (eng_tx_bytes >= TAG_W'(1) && eng_tx_bytes <= TAG_W'(NB)));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_rx && !rx_not_empty) |=> (bus_rdata == '0));

  assert_stray_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_rx) |=> (bus_rdata == '0));

  assert_rx_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_not_full) |=> rx_not_empty);
endmodule

bind sfc_txfront sfc_txfront_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_sfc_txfront.sv
module test_sfc_txfront;
  localparam int DEPTH = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [5:0]  cfg_tx_thr = 6'd1;
  logic        eng_tx_pop = 0;
  logic [31:0] eng_tx_word;
  logic [2:0]  eng_tx_bytes;
  logic        tx_has_data, tx_not_full, tx_below_thr, tx_overflow;
  logic        eng_rx_push = 0;
  logic [31:0] eng_rx_word = 0;
  logic [2:0]  eng_rx_bytes = 0;
  logic        rx_not_empty, rx_not_full;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_txd[$];
  int          m_txn[$];
  logic [31:0] m_rx[$];
  logic        m_ovf = 0;
  logic [31:0] m_rdata = 0;

  always #10 clk = ~clk;

  sfc_txfront i_sfc_txfront (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tx_tag_of(logic [7:0] a);
    case (a)
      8'h1C: return 4;
      8'h80: return 1;
      8'h84: return 2;
      8'h88: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] rx_mask(logic [31:0] w, int n);
    if (n == 1) return w & 32'h0000_00FF;
    if (n == 2) return w & 32'h0000_FFFF;
    if (n == 3) return w & 32'h00FF_FFFF;
    return w;
  endfunction

  task automatic model_step();
    int  tag = tx_tag_of(bus_addr);
    bit  txfull = (m_txd.size() == DEPTH);
    bit  rxfull = (m_rx.size() == DEPTH);
    bit  rxhad  = (m_rx.size() > 0);
    if (bus_wr && tag != 0 && txfull) m_ovf = 1;
    if (eng_tx_pop && m_txd.size() > 0) begin
      void'(m_txd.pop_front());
      void'(m_txn.pop_front());
    end
    if (bus_wr && tag != 0 && !txfull) begin
      m_txd.push_back(bus_wdata);
      m_txn.push_back(tag);
    end
    if (bus_rd) begin
      if (bus_addr == 8'h20 && rxhad) m_rdata = m_rx.pop_front();
      else m_rdata = 0;
    end
    if (eng_rx_push && !rxfull) m_rx.push_back(rx_mask(eng_rx_word, int'(eng_rx_bytes)));
  endtask

  task automatic compare();
    chk(tx_not_full === (m_txd.size() < DEPTH), "R4 tx_not_full", 32'(tx_not_full), 32'(m_txd.size() < DEPTH));
    chk(tx_has_data === (m_txd.size() > 0), "R6 tx_has_data", 32'(tx_has_data), 32'(m_txd.size() > 0));
    if (m_txd.size() > 0) begin
      chk(eng_tx_word === m_txd[0], "R1 head word", eng_tx_word, m_txd[0]);
      chk(int'(eng_tx_bytes) == m_txn[0], "R2 head tag", 32'(eng_tx_bytes), 32'(m_txn[0]));
    end
    chk(tx_below_thr === (m_txd.size() < int'(cfg_tx_thr)), "R7 below_thr",
        32'(tx_below_thr), 32'(m_txd.size() < int'(cfg_tx_thr)));
    chk(tx_overflow === m_ovf, "R5 overflow", 32'(tx_overflow), 32'(m_ovf));
    chk(bus_rdata === m_rdata, "R9 rdata", bus_rdata, m_rdata);
    chk(rx_not_empty === (m_rx.size() > 0), "R10 rx_not_empty", 32'(rx_not_empty), 32'(m_rx.size() > 0));
    chk(rx_not_full === (m_rx.size() < DEPTH), "R8 rx_not_full", 32'(rx_not_full), 32'(m_rx.size() < DEPTH));
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_txd.delete(); m_txn.delete(); m_rx.delete();
    m_ovf = 0; m_rdata = 0;
    // R11: state right after reset
    chk(tx_has_data === 1'b0 && rx_not_empty === 1'b0, "R11 queues empty",
        {30'd0, tx_has_data, rx_not_empty}, 32'd0);
    chk(tx_overflow === 1'b0, "R11 overflow clear", 32'(tx_overflow), 32'd0);
    chk(bus_rdata === 32'd0, "R11 rdata zero", bus_rdata, 32'd0);
    compare();
  endtask

  task automatic bwrite(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic bread(logic [7:0] a);
    bus_rd = 1; bus_addr = a; step();
  endtask

  task automatic rxpush(logic [31:0] w, logic [2:0] n);
    eng_rx_push = 1; eng_rx_word = w; eng_rx_bytes = n; step();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R1, R2: each transmit address and its tag
    bwrite(8'h1C, 32'hA1B2_C3D4);
    bwrite(8'h80, 32'h1111_11E1);
    bwrite(8'h84, 32'h2222_E2E2);
    bwrite(8'h88, 32'h33E3_E3E3);
    chk(eng_tx_bytes == 3'd4 && eng_tx_word == 32'hA1B2_C3D4, "R1 full word first",
        eng_tx_word, 32'hA1B2_C3D4);
    eng_tx_pop = 1; step();
    chk(eng_tx_bytes == 3'd1, "R2 one byte tag", 32'(eng_tx_bytes), 32'd1);
    eng_tx_pop = 1; step();
    chk(eng_tx_bytes == 3'd2, "R2 two byte tag", 32'(eng_tx_bytes), 32'd2);
    eng_tx_pop = 1; step();
    chk(eng_tx_bytes == 3'd3 && eng_tx_word == 32'h33E3_E3E3, "R2 three byte tag",
        32'(eng_tx_bytes), 32'd3);
    eng_tx_pop = 1; step();

    // R6: pop on empty is ignored
    eng_tx_pop = 1; step();
    chk(tx_has_data === 1'b0, "R6 empty pop", 32'(tx_has_data), 32'd0);

    // R3: stray addresses
    bwrite(8'h20, 32'hDEAD_0001);
    bwrite(8'h00, 32'hDEAD_0002);
    bwrite(8'h8C, 32'hDEAD_0003);
    chk(tx_has_data === 1'b0, "R3 stray write ignored", 32'(tx_has_data), 32'd0);
    rxpush(32'h5555_AAAA, 3'd4);
    bread(8'h1C);
    chk(bus_rdata === 32'd0 && rx_not_empty === 1'b1, "R3 stray read", bus_rdata, 32'd0);
    bread(8'h20);
    chk(bus_rdata === 32'h5555_AAAA, "R9 pop word", bus_rdata, 32'h5555_AAAA);

    // R4, R5, R7: fill to 63, then overflow
    cfg_tx_thr = 6'd10;
    for (int i = 0; i < DEPTH; i++) bwrite(8'h1C, 32'h1000_0000 + 32'(i));
    chk(tx_not_full === 1'b0, "R4 full at 63", 32'(tx_not_full), 32'd0);
    chk(tx_below_thr === 1'b0, "R7 above threshold", 32'(tx_below_thr), 32'd0);
    bwrite(8'h84, 32'hBAD0_BAD0);
    chk(tx_overflow === 1'b1, "R5 overflow set", 32'(tx_overflow), 32'd1);
    bus_wr = 1; bus_addr = 8'h80; bus_wdata = 32'hBAD1_BAD1; eng_tx_pop = 1; step();
    chk(tx_not_full === 1'b1, "R6 write dropped when full with pop", 32'(tx_not_full), 32'd1);
    cfg_tx_thr = 6'd63;
    for (int i = 0; i < DEPTH; i++) begin eng_tx_pop = 1; step(); end
    chk(tx_has_data === 1'b0 && tx_overflow === 1'b1, "R5 sticky after drain",
        32'(tx_overflow), 32'd1);
    cfg_tx_thr = 6'd0;
    step();
    chk(tx_below_thr === 1'b0, "R7 zero threshold", 32'(tx_below_thr), 32'd0);

    // R8, R9: alignment, empty read, receive full
    cfg_tx_thr = 6'd1;
    bread(8'h20);
    chk(bus_rdata === 32'd0, "R9 empty read zero", bus_rdata, 32'd0);
    rxpush(32'hFFEE_DDCC, 3'd1);
    rxpush(32'hFFEE_DDCC, 3'd2);
    rxpush(32'hFFEE_DDCC, 3'd3);
    rxpush(32'hFFEE_DDCC, 3'd0);
    bread(8'h20);
    chk(bus_rdata === 32'h0000_00CC, "R8 one byte", bus_rdata, 32'h0000_00CC);
    bread(8'h20);
    chk(bus_rdata === 32'h0000_DDCC, "R8 two bytes", bus_rdata, 32'h0000_DDCC);
    bread(8'h20);
    chk(bus_rdata === 32'h00EE_DDCC, "R8 three bytes", bus_rdata, 32'h00EE_DDCC);
    bread(8'h20);
    chk(bus_rdata === 32'hFFEE_DDCC, "R8 full word", bus_rdata, 32'hFFEE_DDCC);
    for (int i = 0; i < DEPTH + 2; i++) rxpush(32'h2000_0000 + 32'(i), 3'd4);
    chk(rx_not_full === 1'b0, "R8 receive full", 32'(rx_not_full), 32'd0);
    for (int i = 0; i < DEPTH; i++) bread(8'h20);
    chk(bus_rdata === 32'h2000_003E && rx_not_empty === 1'b0, "R8 extra pushes dropped",
        bus_rdata, 32'h2000_003E);

    // mixed traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom_range(0, 5));
      case (sel)
        0: bus_addr = 8'h1C; 1: bus_addr = 8'h80; 2: bus_addr = 8'h84;
        3: bus_addr = 8'h88; 4: bus_addr = 8'h20; default: bus_addr = 8'h04;
      endcase
      bus_wr       = ($urandom_range(0, 2) != 0);
      bus_rd       = !bus_wr && ($urandom_range(0, 1) == 1);
      bus_wdata    = $urandom;
      eng_tx_pop   = ($urandom_range(0, 2) == 0);
      eng_rx_push  = ($urandom_range(0, 1) == 1);
      eng_rx_word  = $urandom;
      eng_rx_bytes = 3'($urandom_range(0, 7));
      cfg_tx_thr   = 6'($urandom_range(0, 63));
      step();
    end

    // R11: reset clears a set overflow flag
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule